// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N. A dual-modulus prescaler divides by P or P+1. A small swallow counter sets how many prescaler outputs use the larger modulus in each output period, and a wider main counter sets how many prescaler outputs make up the whole period. The total ratio is N = P*B + A. Once per N input cycles the block emits a single-cycle pulse, which a phase detector uses as its feedback input.

The settings are A (5 bits), B (13 bits) and a modulus-select bit. They are sampled at the end of each output period, so a change never breaks the period in progress. A synchronous hold input stops both counters at their load point and loads any legal setting at once. When hold is released, counting restarts from a known phase. A setting that breaks the programming rules raises an error flag and is not loaded, so the divider keeps running with the last legal setting.

A build parameter picks one of two modulus families: 32 or 16 for the wide variant, and 16 or 8 for the low-frequency variant. The modulus-select bit picks the larger member of the pair when it is 1.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While the setting is unchanged, consecutive `div_out` pulses are exactly P*B + A input clock cycles apart.
- R2: With the default wide variant, `modsel`=1 selects P=32 and `modsel`=0 selects P=16. The low-frequency variant uses 16 and 8.
- R3: In each output period, the first A prescaler outputs take P+1 input cycles each and the other B−A take P each. This also holds at the limits A=0, A=B, A=P and A=31.
- R4: Each `div_out` pulse lasts exactly one input clock cycle.
- R5: While `hold` is 1, `div_out` stays 0 and both counters sit at their load point. After `hold` falls, the first pulse appears on the N-th rising clock edge at which `hold` is low.
- R6: A setting is legal when B ≥ 3, A ≤ B and A ≤ P. On the clock edge after an input setting is applied, `cfg_err` shows 1 if that setting is illegal and 0 if it is legal.
- R7: An illegal input setting is never loaded. The divider keeps dividing by the last legal N, whether `hold` is high or low.
- R8: A legal setting applied while the divider runs takes effect from the next output period. The period in progress completes with the old ratio.
- R9: Reset (active-low `rst_n`) clears `div_out` and `cfg_err`. It loads the setting A=0, B=3, P=low modulus, so the first period after reset is 3×P_low cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Synchronous hold: counters parked at load point, setting loads immediately |
| modsel | input | 1 | Prescaler modulus select (1 = larger base modulus) |
| a_val | input | 5 | Swallow count A |
| b_val | input | 13 | Main count B |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | Registered flag: current input setting is illegal |

## Verification
The ratio is measured in input clocks for random legal settings of both moduli, and for directed settings: A=0, A=B, A=P, A=31 and a large B. These tell apart a wrong base modulus, a swallow phase of the wrong length, and a main count that is off by one. Illegal settings of each kind (B below 3, A above B, A above P) are applied during hold and then kept on the inputs after hold is released, so the measured period shows whether a bad value leaked in. A setting changed partway through a period, and the fixed setting loaded by reset, separate loading at the period boundary from loading at once.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int A_W   = 5;
  localparam int B_W   = 13;
  localparam int P_W   = 6;
  localparam int B_MIN = 3;

  // Base modulus for a variant and select bit (R2)
  function automatic logic [P_W-1:0] base_modulus(input bit wide, input logic sel);
    logic [P_W-1:0] p;
    if (wide) p = sel ? P_W'(32) : P_W'(16);
    else      p = sel ? P_W'(16) : P_W'(8);
    return p;
  endfunction

  // Programming rules (R6)
  function automatic logic cfg_ok(input logic [P_W-1:0] p,
                                  input logic [A_W-1:0] a,
                                  input logic [B_W-1:0] b);
    logic [B_W-1:0] a_ext;
    logic [B_W-1:0] p_ext;
    a_ext = {{(B_W-A_W){1'b0}}, a};
    p_ext = {{(B_W-P_W){1'b0}}, p};
    return (b >= B_W'(B_MIN)) && (a_ext <= b) && (a_ext <= p_ext);
  endfunction
endpackage

// File: rtl/psd_cfg_reg.sv
module psd_cfg_reg
  import psd_pkg::*;
#(
  parameter bit WIDE_VARIANT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           end_evt,
  input  logic           sel_in,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [A_W-1:0] cfg_a,
  output logic [B_W-1:0] cfg_b,
  output logic [P_W-1:0] cfg_p,
  output logic           cfg_err
);
  logic           cfg_sel;
  logic [P_W-1:0] p_in;
  logic           legal_in;
  logic           take;

  assign p_in     = base_modulus(WIDE_VARIANT, sel_in);
  assign legal_in = cfg_ok(p_in, a_in, b_in);
  assign take     = (hold || end_evt) && legal_in;   // R8 boundary load, R5 load in hold

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel <= 1'b0;
      cfg_a   <= '0;
      cfg_b   <= B_W'(B_MIN);
      cfg_err <= 1'b0;
    end else begin
      if (take) begin
        cfg_sel <= sel_in;
        cfg_a   <= a_in;
        cfg_b   <= b_in;
      end
      cfg_err <= !legal_in;
    end
  end

  assign cfg_p = base_modulus(WIDE_VARIANT, cfg_sel);

  AST_CFG_IGNORE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_in |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(cfg_sel)));  // R7
  AST_CFG_STAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok(cfg_p, cfg_a, cfg_b));  // R6
  AST_CFG_MIDPERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !end_evt) |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(cfg_sel)));  // R8
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           swallow,
  input  logic [P_W-1:0] p_base,
  output logic           pre_tc
);
  logic [P_W-1:0] cnt;
  logic [P_W-1:0] last;

  // P+1 while swallowing, else P (R3)
  assign last   = swallow ? p_base : p_base - 1'b1;
  assign pre_tc = !hold && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (pre_tc) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= p_base);  // R3
  AST_PRE_HOLD_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));  // R5
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
  import psd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           pre_tc,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  output logic           swallow,
  output logic           end_evt
);
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic           last_b;

  assign swallow = (a_cnt < cfg_a);
  assign last_b  = (b_cnt == cfg_b - 1'b1);
  assign end_evt = pre_tc && last_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (hold || end_evt) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (pre_tc) begin
      b_cnt <= b_cnt + 1'b1;
      if (swallow) a_cnt <= a_cnt + 1'b1;
    end
  end

  AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    a_cnt <= cfg_a);  // R3
  AST_MAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt < cfg_b);  // R1
  AST_SWALLOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> ((A_W+1)'(a_cnt) + (A_W+1)'(swallow) == (A_W+1)'(cfg_a)));  // R3
  AST_HOLD_LOAD_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (a_cnt == '0 && b_cnt == '0));  // R5
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter bit WIDE_VARIANT = 1'b1
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           modsel,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           div_out,
  output logic           cfg_err
);
  logic [A_W-1:0] cfg_a;
  logic [B_W-1:0] cfg_b;
  logic [P_W-1:0] cfg_p;
  logic           swallow;
  logic           pre_tc;
  logic           end_evt;

  psd_cfg_reg #(.WIDE_VARIANT(WIDE_VARIANT)) u_cfg (
    .clk(clk_in), .rst_n(rst_n), .hold(hold), .end_evt(end_evt),
    .sel_in(modsel), .a_in(a_val), .b_in(b_val),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_p(cfg_p), .cfg_err(cfg_err)
  );

  psd_prescaler u_pre (
    .clk(clk_in), .rst_n(rst_n), .hold(hold), .swallow(swallow),
    .p_base(cfg_p), .pre_tc(pre_tc)
  );

  psd_swallow_ctrl u_ctl (
    .clk(clk_in), .rst_n(rst_n), .hold(hold), .pre_tc(pre_tc),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .swallow(swallow), .end_evt(end_evt)
  );

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)    div_out <= 1'b0;
    else if (hold) div_out <= 1'b0;
    else           div_out <= end_evt;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    div_out |=> !div_out);  // R4
  AST_HOLD_QUIET: assert property (@(posedge clk_in) disable iff (!rst_n)
    hold |=> !div_out);  // R5
endmodule

// File: tb/tb_pulse_swallow_divider.sv
module tb_pulse_swallow_divider;
  logic        clk_in = 1'b0;
  logic        rst_n  = 1'b0;
  logic        hold   = 1'b0;
  logic        modsel = 1'b1;
  logic [4:0]  a_val  = 5'd5;
  logic [12:0] b_val  = 13'd10;
  logic        div_out;
  logic        cfg_err;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk_in = ~clk_in;

  pulse_swallow_divider dut (
    .clk_in(clk_in), .rst_n(rst_n), .hold(hold), .modsel(modsel),
    .a_val(a_val), .b_val(b_val), .div_out(div_out), .cfg_err(cfg_err)
  );

  function automatic int exp_ratio(bit sel, int a, int b);
    int p;
    p = sel ? 32 : 16;
    return (p + 1) * a + p * (b - a);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_in);
    @(negedge clk_in);
  endtask

  task automatic count_to_pulse(input int start, output int cnt);
    cnt = start;
    do begin
      step();
      cnt++;
    end while (!div_out && cnt < 300000);
  endtask

  task automatic drive(bit sel, int a, int b);
    modsel = sel;
    a_val  = a[4:0];
    b_val  = b[12:0];
  endtask

  task automatic load_and_measure(bit sel, int a, int b, string tag);
    int c;
    int e;
    e = exp_ratio(sel, a, b);
    hold = 1'b1;
    drive(sel, a, b);
    step();
    check(div_out == 1'b0, {tag, " R5 quiet in hold"}, int'(div_out), 0);
    step();
    check(cfg_err == 1'b0, {tag, " R6 legal"}, int'(cfg_err), 0);
    hold = 1'b0;
    count_to_pulse(0, c);
    check(c == e, {tag, " R5 first after release"}, c, e);
    count_to_pulse(0, c);
    check(c == e, {tag, " R1 period"}, c, e);
    step();
    check(div_out == 1'b0, {tag, " R4 width"}, int'(div_out), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_in);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    void'($urandom(32'd7741));
    step(); step(); step();
    check(div_out == 1'b0, "R9 div_out in reset", int'(div_out), 0);
    check(cfg_err == 1'b0, "R9 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    count_to_pulse(0, c);
    check(c == 48, "R9 default period", c, 48);
    count_to_pulse(0, c);
    check(c == exp_ratio(1, 5, 10), "R8 boundary load after reset", c, exp_ratio(1, 5, 10));
    step();
    check(div_out == 1'b0, "R4 width after reset", int'(div_out), 0);

    load_and_measure(1, 0, 3,   "R2 P32 Bmin");
    load_and_measure(0, 0, 3,   "R2 P16 Bmin");
    load_and_measure(0, 3, 3,   "R3 A=B");
    load_and_measure(0, 16, 20, "R3 A=P");
    load_and_measure(1, 31, 31, "R3 Amax");
    load_and_measure(1, 0, 600, "R1 large B");

    // R6 / R7: illegal settings
    load_and_measure(0, 2, 5, "R7 base");
    hold = 1'b1;
    drive(0, 2, 2);
    step();
    check(cfg_err == 1'b1, "R6 B below 3", int'(cfg_err), 1);
    drive(0, 7, 5);
    step();
    check(cfg_err == 1'b1, "R6 A above B", int'(cfg_err), 1);
    drive(0, 17, 40);
    step();
    check(cfg_err == 1'b1, "R6 A above P", int'(cfg_err), 1);
    hold = 1'b0;
    count_to_pulse(0, c);
    check(c == 82, "R7 kept after hold", c, 82);
    count_to_pulse(0, c);
    check(c == 82, "R7 kept while running", c, 82);
    check(cfg_err == 1'b1, "R6 still flagged", int'(cfg_err), 1);

    // R8: change part-way through a period
    load_and_measure(1, 3, 4, "R8 base");
    repeat (9) step();
    drive(0, 0, 3);
    count_to_pulse(10, c);
    check(c == 131, "R8 current period keeps old", c, 131);
    count_to_pulse(0, c);
    check(c == 48, "R8 next period uses new", c, 48);

    for (int t = 0; t < 12; t++) begin
      bit sel;
      int p;
      int b;
      int amax;
      int a;
      sel  = bit'($urandom % 2);
      p    = sel ? 32 : 16;
      b    = 3 + int'($urandom % 58);
      amax = (p < b) ? p : b;
      if (amax > 31) amax = 31;
      a    = int'($urandom % (amax + 1));
      load_and_measure(sel, a, b, "R1 R3 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule